// File: doc/BRIEF.md
# Per-Core Countdown and Deadline Interrupt Timer

This block is a private timer owned by one processor core. Software sets it up through a small write port: a configuration word that holds the interrupt vector, the operating mode and a mask bit; a countdown value; and an absolute deadline. When the programmed event occurs, the timer drives a single-cycle pulse and presents the vector on a separate bus in the same cycle. The interrupt logic of the core takes it from there.

Three operating modes exist. In one-shot mode the timer counts down from the written value, fires once and then stops. In periodic mode it fires each time the count runs out, reloads the written value and continues. In deadline mode it ignores the countdown and watches a free-running 64-bit cycle counter that comes from outside the block. It fires once when that counter is equal to or above the programmed deadline. Every core has its own instance, and instances share no state.

Top module: `lt_timer`

## Requirements
- R1: After reset, and for as long as no count or deadline is written, no pulse occurs and `irq_vec` reads 0.
- R2: One-shot mode (mode code 0, or the unused code 3): a nonzero count N written at clock edge k gives a pulse that is visible after edge k+N. The timer then stays disarmed and gives no further pulse.
- R3: Periodic mode (mode code 1): a count N written at edge k gives a pulse after every edge k+N, k+2N, k+3N and so on. With N=1 the pulse is present on every cycle.
- R4: Deadline mode (mode code 2): the pulse follows the first edge at which `cyc_cnt` is at or above the deadline. This edge is the next one when the deadline has already passed. The timer fires only once per written deadline.
- R5: Vectors 0 to 31 produce no pulse. Any pulse carries a vector of 32 or more.
- R6: With the mask bit set, the countdown keeps running and keeps reloading, but no pulse is produced. Clearing the mask lets the next expiry fire on the original schedule.
- R7: Writing a count of 0 disarms the countdown. Writing a deadline of 0 disarms the deadline match.
- R8: Writing a new count while a countdown is running restarts it from the new value at once.
- R9: A pulse lasts one cycle per expiry, occurs only as the result of a timer event, and carries the configured vector on `irq_vec` in that same cycle.
- R10: Register selects are 0 = configuration, 1 = count (low 32 bits of `wr_data`), 2 = deadline (all 64 bits). Configuration fields are: vector in bits [7:0], mode in bits [9:8], mask in bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 config, 1 count, 2 deadline) |
| wr_data | input | 64 | Write data |
| cyc_cnt | input | 64 | Free-running cycle counter |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vec | output | 8 | Vector for the pulse, 0 when idle |

## Verification
If the down-counter holds a wrong value, the error appears directly as a pulse at the wrong edge. The bench therefore measures the cycle offset of every pulse from the write that armed it, not only whether a pulse occurred. If the armed flag or the reload value is corrupted, the effect appears at the next expiry: an extra pulse after a one-shot, a missing pulse or a shifted period in periodic mode. Each window runs several periods so that this expiry falls inside it. A deadline compare that is wrong shows up when the bench reads the cycle counter value at the pulse, and it must equal the deadline exactly.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int unsigned LT_VEC_W   = 8;
  localparam int unsigned LT_VEC_MIN = 32;

  localparam logic [1:0] SEL_CFG = 2'd0;
  localparam logic [1:0] SEL_CNT = 2'd1;
  localparam logic [1:0] SEL_DL  = 2'd2;

  localparam int unsigned CFG_VEC_LSB  = 0;
  localparam int unsigned CFG_MODE_LSB = 8;
  localparam int unsigned CFG_MASK_BIT = 16;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_PER  = 2'd1,
    MODE_DL   = 2'd2,
    MODE_RSV  = 2'd3
  } lt_mode_e;

  function automatic logic vec_usable(input logic [LT_VEC_W-1:0] v);
    return v >= LT_VEC_W'(LT_VEC_MIN);
  endfunction
endpackage

// File: rtl/lt_cfg_regs.sv
module lt_cfg_regs
  import lt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  output lt_mode_e            mode,
  output logic [LT_VEC_W-1:0] vec,
  output logic                mask
);
  logic cfg_we;
  assign cfg_we = wr_en && (wr_sel == SEL_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_ONCE;
      vec  <= '0;
      mask <= 1'b0;
    end else if (cfg_we) begin
      mode <= lt_mode_e'(wr_data[CFG_MODE_LSB +: 2]);
      vec  <= wr_data[CFG_VEC_LSB +: LT_VEC_W];
      mask <= wr_data[CFG_MASK_BIT];
    end
  end
endmodule

// File: rtl/lt_countdown.sv
module lt_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload_en,
  output logic             fire,
  output logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] period
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic             expire,
                                            input logic             rel,
                                            input logic [CNT_W-1:0] p);
    if (expire) return rel ? p : '0;
    return c - CNT_W'(1);
  endfunction

  assign fire = armed && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      period <= '0;
      armed  <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      period <= load_val;
      armed  <= (load_val != '0);
    end else if (armed) begin
      cnt   <= step(cnt, fire, reload_en, period);
      armed <= !(fire && !reload_en);
    end
  end
endmodule

// File: rtl/lt_deadline.sv
module lt_deadline #(
  parameter int CYC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CYC_W-1:0] load_val,
  input  logic [CYC_W-1:0] cyc,
  output logic             fire,
  output logic             armed
);
  logic [CYC_W-1:0] target;

  function automatic logic reached(input logic [CYC_W-1:0] now,
                                   input logic [CYC_W-1:0] tgt);
    return now >= tgt;
  endfunction

  assign fire = armed && reached(cyc, target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target <= '0;
      armed  <= 1'b0;
    end else if (load) begin
      target <= load_val;
      armed  <= (load_val != '0);
    end else if (fire) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/lt_timer.sv
module lt_timer
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int CYC_W  = 64,
  parameter int DATA_W = CYC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [CYC_W-1:0]    cyc_cnt,
  output logic                irq_pulse,
  output logic [LT_VEC_W-1:0] irq_vec
);
  lt_mode_e            cfg_mode;
  logic [LT_VEC_W-1:0] cfg_vec;
  logic                cfg_mask;

  logic cnt_ld, dl_ld;
  logic cd_fire, cd_armed, dl_fire, dl_armed;
  logic [CNT_W-1:0] cd_cnt, cd_period;
  logic src_fire, fire_ok;

  assign cnt_ld = wr_en && (wr_sel == SEL_CNT);
  assign dl_ld  = wr_en && (wr_sel == SEL_DL);

  lt_cfg_regs #(.DATA_W(DATA_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mode(cfg_mode), .vec(cfg_vec), .mask(cfg_mask)
  );

  lt_countdown #(.CNT_W(CNT_W)) cd_i (
    .clk(clk), .rst_n(rst_n), .load(cnt_ld),
    .load_val(wr_data[CNT_W-1:0]), .reload_en(cfg_mode == MODE_PER),
    .fire(cd_fire), .armed(cd_armed), .cnt(cd_cnt), .period(cd_period)
  );

  lt_deadline #(.CYC_W(CYC_W)) dl_i (
    .clk(clk), .rst_n(rst_n), .load(dl_ld),
    .load_val(wr_data[CYC_W-1:0]), .cyc(cyc_cnt),
    .fire(dl_fire), .armed(dl_armed)
  );

  assign src_fire = (cfg_mode == MODE_DL) ? dl_fire : cd_fire;
  assign fire_ok  = src_fire && !cfg_mask && vec_usable(cfg_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      irq_vec   <= '0;
    end else begin
      irq_pulse <= fire_ok;
      irq_vec   <= fire_ok ? cfg_vec : '0;
    end
  end
endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cnt_ld,
  input logic                dl_ld,
  input logic [DATA_W-1:0]   wr_data,
  input logic                irq_pulse,
  input logic [LT_VEC_W-1:0] irq_vec,
  input lt_mode_e            cfg_mode,
  input logic                cfg_mask,
  input logic                cd_fire,
  input logic                dl_fire,
  input logic [CNT_W-1:0]    cd_cnt,
  input logic [CNT_W-1:0]    cd_period
);
  a_r5_vec_floor: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_vec >= LT_VEC_W'(LT_VEC_MIN));

  a_r6_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(cfg_mask));

  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(cd_fire || dl_fire));

  a_r2_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_fire && cfg_mode != MODE_PER && !cnt_ld) |=> (cd_cnt == '0));

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_fire && cfg_mode == MODE_PER && !cnt_ld) |=> (cd_cnt == $past(cd_period)));

  a_r4_dl_once: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_fire && !dl_ld) |=> !dl_fire);

  a_r7_zero_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ld && wr_data[CNT_W-1:0] == '0) |=> (!cd_fire && cd_cnt == '0));
endmodule

bind lt_timer lt_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_ld(cnt_ld), .dl_ld(dl_ld), .wr_data(wr_data),
  .irq_pulse(irq_pulse), .irq_vec(irq_vec), .cfg_mode(cfg_mode),
  .cfg_mask(cfg_mask), .cd_fire(cd_fire), .dl_fire(dl_fire),
  .cd_cnt(cd_cnt), .cd_period(cd_period)
);

// File: tb/lt_timer_tb_top.sv
module lt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [63:0] wr_data = '0;
  logic [63:0] cyc_cnt = 64'd1000;
  logic        irq_pulse;
  logic [7:0]  irq_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) cyc_cnt <= cyc_cnt + 64'd1;

  lt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cyc_cnt(cyc_cnt),
    .irq_pulse(irq_pulse), .irq_vec(irq_vec)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  vec;
    logic        mask;
    logic [15:0] n;
    logic [7:0]  first;
    logic [7:0]  npulse;
  } tvec_t;

  localparam int WIN = 40;
  localparam tvec_t TBL [8] = '{
    '{2'd0, 8'd40,  1'b0, 16'd5,  8'd5,  8'd1},   // R2 one-shot
    '{2'd1, 8'd255, 1'b0, 16'd7,  8'd7,  8'd5},   // R3 periodic
    '{2'd1, 8'd32,  1'b0, 16'd1,  8'd1,  8'd40},  // R3 N=1, R5 lowest usable
    '{2'd0, 8'd31,  1'b0, 16'd3,  8'd0,  8'd0},   // R5 below floor
    '{2'd1, 8'd90,  1'b1, 16'd4,  8'd0,  8'd0},   // R6 masked
    '{2'd0, 8'd100, 1'b0, 16'd1,  8'd1,  8'd1},   // R2 N=1
    '{2'd1, 8'd64,  1'b0, 16'd10, 8'd10, 8'd4},   // R3 long period
    '{2'd3, 8'd50,  1'b0, 16'd6,  8'd6,  8'd1}    // R10 code 3 acts one-shot
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [63:0] cfg(input logic [1:0] m, input logic [7:0] v, input logic mk);
    return {47'd0, mk, 6'd0, m, v};
  endfunction

  task automatic watch(input int win, input logic [7:0] expv, input string tag,
                       output int first, output int npulse, output longint first_cyc);
    first = 0; npulse = 0; first_cyc = 0;
    for (int j = 1; j <= win; j++) begin
      @(negedge clk);
      if (irq_pulse) begin
        npulse++;
        if (first == 0) begin first = j; first_cyc = longint'(cyc_cnt); end
        check(irq_vec == expv, {tag, " R9 vector"}, irq_vec, expv);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int f, np;
    longint fc, d;
    repeat (3) @(negedge clk);
    check(irq_pulse == 1'b0, "R1 reset pulse", irq_pulse, 0);
    check(irq_vec == 8'd0, "R1 reset vec", irq_vec, 0);
    rst_n = 1'b1;
    watch(10, 8'd0, "R1", f, np, fc);
    check(np == 0, "R1 idle after reset", np, 0);

    foreach (TBL[i]) begin
      wr(2'd1, 64'd0);
      wr(2'd0, cfg(TBL[i].mode, TBL[i].vec, TBL[i].mask));
      wr(2'd1, {48'd0, TBL[i].n});
      watch(WIN, TBL[i].vec, "R2/R3 table", f, np, fc);
      check(f == int'(TBL[i].first), "R2/R3/R5/R6/R10 first pulse", f, TBL[i].first);
      check(np == int'(TBL[i].npulse), "R2/R3/R5/R6/R10 pulse count", np, TBL[i].npulse);
    end

    // R8 restart
    wr(2'd1, 64'd0);
    wr(2'd0, cfg(2'd0, 8'd70, 1'b0));
    wr(2'd1, 64'd20);
    watch(5, 8'd70, "R8", f, np, fc);
    check(np == 0, "R8 no early pulse", np, 0);
    wr(2'd1, 64'd3);
    watch(30, 8'd70, "R8", f, np, fc);
    check(f == 3, "R8 restart delay", f, 3);
    check(np == 1, "R8 single pulse", np, 1);

    // R6 masked keeps counting
    wr(2'd1, 64'd0);
    wr(2'd0, cfg(2'd1, 8'd88, 1'b1));
    wr(2'd1, 64'd4);
    watch(5, 8'd88, "R6", f, np, fc);
    check(np == 0, "R6 masked silent", np, 0);
    wr(2'd0, cfg(2'd1, 8'd88, 1'b0));
    watch(10, 8'd88, "R6", f, np, fc);
    check(f == 2, "R6 phase kept", f, 2);

    // R7 zero count disarms periodic
    wr(2'd1, 64'd0);
    watch(20, 8'd88, "R7", f, np, fc);
    check(np == 0, "R7 zero count", np, 0);

    // R4 deadline in future
    wr(2'd0, cfg(2'd2, 8'd77, 1'b0));
    d = longint'(cyc_cnt) + 12;
    wr(2'd2, 64'(d));
    watch(30, 8'd77, "R4", f, np, fc);
    check(fc == d, "R4 fires at deadline", fc, d);
    check(np == 1, "R4 fires once", np, 1);

    // R4 deadline already passed
    d = longint'(cyc_cnt) - 5;
    wr(2'd2, 64'(d));
    watch(10, 8'd77, "R4", f, np, fc);
    check(f == 1, "R4 past deadline immediate", f, 1);

    // R7 zero deadline
    wr(2'd2, 64'd0);
    watch(20, 8'd77, "R7", f, np, fc);
    check(np == 0, "R7 zero deadline", np, 0);

    // R6 masked deadline
    wr(2'd0, cfg(2'd2, 8'd77, 1'b1));
    d = longint'(cyc_cnt) + 4;
    wr(2'd2, 64'(d));
    watch(15, 8'd77, "R6", f, np, fc);
    check(np == 0, "R6 masked deadline", np, 0);

    // R1 reset mid-run
    wr(2'd0, cfg(2'd1, 8'd99, 1'b0));
    wr(2'd1, 64'd2);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(irq_pulse == 1'b0, "R1 reset clears pulse", irq_pulse, 0);
    rst_n = 1'b1;
    watch(20, 8'd0, "R1", f, np, fc);
    check(np == 0, "R1 disarmed after reset", np, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule